// File: doc/BRIEF.md
# Sound Register Bytecode Sequencer

This block is a small hardware interpreter. It runs a compact bytecode program that drives the sixteen 8-bit control registers of a programmable sound generator. The engine fetches one program byte per cycle from an external program memory. It keeps a shadow copy of the sixteen generator registers and does all arithmetic on that copy. Every register it changes is sent out once on a register-write port. The program can branch on whether a register is zero, wait for a number of timer ticks, call and return from subroutines on a four-entry return stack, freeze, or stop.

A host starts a sound by pulsing a start input together with an entry address. A new start can arrive at any time. It drops whatever was running and begins the new program from a clean state. A tick-enable input sets the pace of waits, so the time base is independent of the core clock. The program memory is read combinationally: the data must be valid in the same cycle as the address.

Top module: `snd_seq_engine`

## Requirements
- R1: After reset, `busy_o`, `frozen_o`, `error_o` and `wr_en_o` are low, and the engine fetches nothing until a start.
- R2: In the first instruction byte, bits 7:4 are the opcode and bits 3:0 are the field. Opcodes 1, 2, 9, B, E and F are one byte long, opcode A is three bytes, and all others are two bytes. Opcodes 9, C and D do nothing except advance the program counter by their length.
- R3: Opcode 0 loads the second byte into register `field`. Opcode 1 adds one to it and opcode 2 subtracts one from it, wrapping modulo 256. Each of these produces exactly one write of the register number and its new value.
- R4: Opcode 3 adds the second byte to register `field` and opcode 4 subtracts the second byte from it, modulo 256, with one write each.
- R5: The branch target is the address of the next instruction plus the second byte, taken as a signed 8-bit value. Opcode 5 always branches. Opcode 6 branches when register `field` is zero and opcode 7 branches when it is nonzero. A branch writes no register.
- R6: Opcode 8 pauses for (second byte × 256) tick pulses when `field` is nonzero, and for 4096 tick pulses when `field` is zero. With `tick_i` low, execution makes no progress.
- R7: Opcode A pushes the address of the following instruction and jumps to {second byte, third byte}. Opcode B pops that address and resumes there. The stack holds at most four entries.
- R8: A call made with four entries already on the stack, or a return made with the stack empty, stops execution and raises `error_o`. `error_o` stays high until the next start.
- R9: Opcode E freezes the engine. `frozen_o` goes high, `busy_o` goes low, and no fetch or write happens until a start.
- R10: Opcode F ends the program. `busy_o` drops and no further writes occur.
- R11: A start at any time clears the return stack, the error flag and the freeze, and resumes fetching at `start_addr_i`. It takes priority over the instruction in flight, which is abandoned without a write.
- R12: `wr_en_o` is a one-cycle pulse and occurs only in the cycle after one in which the engine was busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, one cycle |
| start_addr_i | input | 16 | Entry address taken with a start |
| tick_i | input | 1 | Time-base pulse for waits |
| pmem_addr_o | output | 16 | Program memory byte address |
| pmem_data_i | input | 8 | Program memory byte, valid in the same cycle |
| wr_en_o | output | 1 | Register write strobe |
| wr_reg_o | output | 4 | Register number being written |
| wr_data_o | output | 8 | New register value |
| busy_o | output | 1 | Program is executing or waiting |
| frozen_o | output | 1 | Frozen by opcode E |
| error_o | output | 1 | Return stack overflow or underflow |

## Verification
The assertions assume that `start_i` is a synchronous pulse and that `start_addr_i` is stable while it is high. They also assume that the program memory returns a defined byte for every address the engine drives. The bench meets these conditions by driving every input on the falling edge and by filling the whole modelled memory with the stop opcode before each program is placed. It also keeps each program inside the modelled range, so runaway code always lands on a stop. `tick_i` is held either steady or high, so wait lengths can be measured against a fixed time base.

// File: rtl/snd_seq_pkg.sv
// Shared types and opcode constants for the sound bytecode sequencer.
// Assumes 8-bit program bytes with the opcode in the high nibble.
package snd_seq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_FETCH0,
        SQ_FETCH1,
        SQ_FETCH2,
        SQ_EXEC,
        SQ_WAIT,
        SQ_FROZEN
    } sq_state_e;

    localparam logic [3:0] OPC_LOAD  = 4'h0;
    localparam logic [3:0] OPC_INCR  = 4'h1;
    localparam logic [3:0] OPC_DECR  = 4'h2;
    localparam logic [3:0] OPC_ADDV  = 4'h3;
    localparam logic [3:0] OPC_SUBV  = 4'h4;
    localparam logic [3:0] OPC_JUMP  = 4'h5;
    localparam logic [3:0] OPC_JZERO = 4'h6;
    localparam logic [3:0] OPC_JNZ   = 4'h7;
    localparam logic [3:0] OPC_PAUSE = 4'h8;
    localparam logic [3:0] OPC_GOSUB = 4'hA;
    localparam logic [3:0] OPC_BACK  = 4'hB;
    localparam logic [3:0] OPC_HOLD  = 4'hE;
    localparam logic [3:0] OPC_END   = 4'hF;

    // Byte length of an instruction, selected by its opcode
    function automatic logic [1:0] instr_len(input logic [3:0] opc);
        case (opc)
            4'h1, 4'h2, 4'h9, 4'hB, 4'hE, 4'hF: instr_len = 2'd1;
            4'hA:                               instr_len = 2'd3;
            default:                            instr_len = 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/snd_seq_regs.sv
// Shadow copy of the sound generator registers with a registered write port.
// Assumes at most one update per cycle; the update and the output strobe
// are registered on the same edge.
module snd_seq_regs #(
    parameter int NREG = 16,
    parameter int DW   = 8,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    input  logic          we,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    output logic          out_en,
    output logic [IW-1:0] out_idx,
    output logic [DW-1:0] out_data
);

    logic [DW-1:0] shadow_q [NREG];

    // Read port into the shadow copy
    assign rd_data = shadow_q[rd_idx];

    // One storage element per register, each updated when it is selected
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                shadow_q[g] <= '0;
            else if (we && (wr_idx == IW'(g)))
                shadow_q[g] <= wr_data;
        end
    end

    // Copy each update onto the outgoing write port for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_en   <= 1'b0;
            out_idx  <= '0;
            out_data <= '0;
        end else begin
            out_en <= we;
            if (we) begin
                out_idx  <= wr_idx;
                out_data <= wr_data;
            end
        end
    end

endmodule

// File: rtl/snd_seq_stack.sv
// Return-address stack for subroutine calls.
// Assumes the caller never pushes when full or pops when empty; the flags
// are provided so that it can refuse. Clear empties the stack at once.
module snd_seq_stack #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    localparam int LW   = $clog2(DEPTH + 1),
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_data,
    output logic [AW-1:0] top_data,
    output logic          full,
    output logic          empty,
    output logic [LW-1:0] level
);

    logic [AW-1:0] slot_q [DEPTH];
    logic [LW-1:0] level_q;

    assign level    = level_q;
    assign full     = (level_q == LW'(DEPTH));
    assign empty    = (level_q == '0);
    assign top_data = slot_q[IW'(level_q - 1'b1)];

    // Fill level tracking
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            level_q <= '0;
        else if (push && !full)
            level_q <= level_q + 1'b1;
        else if (pop && !empty)
            level_q <= level_q - 1'b1;
    end

    // Storage for return addresses; no reset is needed on the data
    always_ff @(posedge clk) begin
        if (push && !full && !clear)
            slot_q[IW'(level_q)] <= push_data;
    end

endmodule

// File: rtl/snd_seq_delay.sv
// Wait timer: counts units × 2^SCALE_BITS tick pulses after a load.
// Assumes a load and a cancel never arrive together; cancel wins if they do.
module snd_seq_delay #(
    parameter int UW         = 8,
    parameter int SCALE_BITS = 8,
    localparam int CW        = UW + SCALE_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          cancel,
    input  logic [UW-1:0] units,
    input  logic          tick,
    output logic          done
);

    logic [CW-1:0] remain_q;

    assign done = (remain_q == '0);

    // Load scaled count, then step down once per tick
    always_ff @(posedge clk) begin
        if (!rst_n || cancel)
            remain_q <= '0;
        else if (load)
            remain_q <= {units, {SCALE_BITS{1'b0}}};
        else if (tick && !done)
            remain_q <= remain_q - 1'b1;
    end

endmodule

// File: rtl/snd_seq_engine.sv
// Bytecode sequencer top: fetches instructions byte by byte, executes them
// against the shadow registers, and handles branches, waits, calls and
// returns, freeze and stop. Program memory is read combinationally.
// A start request overrides every other action in its cycle.
module snd_seq_engine
    import snd_seq_pkg::*;
#(
    parameter int AW            = 16,
    parameter int DEPTH         = 4,
    parameter int SCALE_BITS    = 8,
    parameter int DEFAULT_UNITS = 16,
    localparam int NREG         = 16,
    localparam int DW           = 8,
    localparam int IW           = $clog2(NREG),
    localparam int LW           = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] start_addr_i,
    input  logic          tick_i,
    output logic [AW-1:0] pmem_addr_o,
    input  logic [7:0]    pmem_data_i,
    output logic          wr_en_o,
    output logic [IW-1:0] wr_reg_o,
    output logic [DW-1:0] wr_data_o,
    output logic          busy_o,
    output logic          frozen_o,
    output logic          error_o
);

    sq_state_e     state_q, state_d;
    logic [AW-1:0] pc_q, pc_d;
    logic [7:0]    op_q, b_q, p2_q;
    logic          err_q, err_d;

    logic [3:0]    opc, fld;
    logic [AW-1:0] next_pc, branch_pc, call_pc;
    logic [DW-1:0] reg_val, reg_new;
    logic          reg_we;
    logic          stk_push, stk_pop, stk_full, stk_empty;
    logic [AW-1:0] stk_top;
    logic [LW-1:0] stack_level;
    logic          dly_load, dly_done;
    logic [7:0]    dly_units;

    assign opc       = op_q[7:4];
    assign fld       = op_q[3:0];
    assign next_pc   = pc_q + {{(AW-2){1'b0}}, instr_len(opc)};
    assign branch_pc = next_pc + {{(AW-8){b_q[7]}}, b_q};
    assign call_pc   = {{(AW-16){1'b0}}, b_q, p2_q};
    assign dly_units = (fld != 4'h0) ? b_q : 8'(DEFAULT_UNITS);

    // Program memory address: instruction start plus the byte being fetched
    always_comb begin
        case (state_q)
            SQ_FETCH1: pmem_addr_o = pc_q + {{(AW-1){1'b0}}, 1'b1};
            SQ_FETCH2: pmem_addr_o = pc_q + {{(AW-2){1'b0}}, 2'd2};
            default:   pmem_addr_o = pc_q;
        endcase
    end

    // Result of the arithmetic opcodes on the selected shadow register
    always_comb begin
        case (opc)
            OPC_LOAD: reg_new = b_q;
            OPC_INCR: reg_new = reg_val + 1'b1;
            OPC_DECR: reg_new = reg_val - 1'b1;
            OPC_ADDV: reg_new = reg_val + b_q;
            OPC_SUBV: reg_new = reg_val - b_q;
            default:  reg_new = reg_val;
        endcase
    end

    // Sequencing: next state, program counter and side-effect strobes
    always_comb begin
        state_d  = state_q;
        pc_d     = pc_q;
        err_d    = err_q;
        reg_we   = 1'b0;
        stk_push = 1'b0;
        stk_pop  = 1'b0;
        dly_load = 1'b0;
        case (state_q)
            SQ_FETCH0: state_d = (instr_len(pmem_data_i[7:4]) == 2'd1) ? SQ_EXEC : SQ_FETCH1;
            SQ_FETCH1: state_d = (instr_len(opc) == 2'd3) ? SQ_FETCH2 : SQ_EXEC;
            SQ_FETCH2: state_d = SQ_EXEC;
            SQ_WAIT:   if (dly_done) state_d = SQ_FETCH0;
            SQ_EXEC: begin
                state_d = SQ_FETCH0;
                pc_d    = next_pc;
                case (opc)
                    OPC_LOAD, OPC_INCR, OPC_DECR, OPC_ADDV, OPC_SUBV:
                        reg_we = 1'b1;
                    OPC_JUMP:  pc_d = branch_pc;
                    OPC_JZERO: if (reg_val == '0) pc_d = branch_pc;
                    OPC_JNZ:   if (reg_val != '0) pc_d = branch_pc;
                    OPC_PAUSE: begin
                        dly_load = 1'b1;
                        state_d  = SQ_WAIT;
                    end
                    OPC_GOSUB: begin
                        if (stk_full) begin
                            err_d   = 1'b1;
                            state_d = SQ_IDLE;
                        end else begin
                            stk_push = 1'b1;
                            pc_d     = call_pc;
                        end
                    end
                    OPC_BACK: begin
                        if (stk_empty) begin
                            err_d   = 1'b1;
                            state_d = SQ_IDLE;
                        end else begin
                            stk_pop = 1'b1;
                            pc_d    = stk_top;
                        end
                    end
                    OPC_HOLD: state_d = SQ_FROZEN;
                    OPC_END:  state_d = SQ_IDLE;
                    default:  ;
                endcase
            end
            default: ;
        endcase
        if (start_i) begin
            state_d  = SQ_FETCH0;
            pc_d     = start_addr_i;
            err_d    = 1'b0;
            reg_we   = 1'b0;
            stk_push = 1'b0;
            stk_pop  = 1'b0;
            dly_load = 1'b0;
        end
    end

    // Control state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            pc_q    <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            err_q   <= err_d;
        end
    end

    // Instruction byte capture during fetch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= '0;
            b_q  <= '0;
            p2_q <= '0;
        end else if (!start_i) begin
            if (state_q == SQ_FETCH0) op_q <= pmem_data_i;
            if (state_q == SQ_FETCH1) b_q  <= pmem_data_i;
            if (state_q == SQ_FETCH2) p2_q <= pmem_data_i;
        end
    end

    assign busy_o   = (state_q != SQ_IDLE) && (state_q != SQ_FROZEN);
    assign frozen_o = (state_q == SQ_FROZEN);
    assign error_o  = err_q;

    snd_seq_regs #(.NREG(NREG), .DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (fld),
        .rd_data  (reg_val),
        .we       (reg_we),
        .wr_idx   (fld),
        .wr_data  (reg_new),
        .out_en   (wr_en_o),
        .out_idx  (wr_reg_o),
        .out_data (wr_data_o)
    );

    snd_seq_stack #(.DEPTH(DEPTH), .AW(AW)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start_i),
        .push      (stk_push),
        .pop       (stk_pop),
        .push_data (next_pc),
        .top_data  (stk_top),
        .full      (stk_full),
        .empty     (stk_empty),
        .level     (stack_level)
    );

    snd_seq_delay #(.UW(8), .SCALE_BITS(SCALE_BITS)) u_delay (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (dly_load),
        .cancel (start_i),
        .units  (dly_units),
        .tick   (tick_i),
        .done   (dly_done)
    );

endmodule

// File: rtl/snd_seq_engine_chk.sv
// Property checker for the sequencer, bound to every instance of the top.
// Assumes start_i is a single synchronous pulse.
module snd_seq_engine_chk #(
    parameter int DEPTH = 4,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          wr_en_o,
    input logic          busy_o,
    input logic          frozen_o,
    input logic          error_o,
    input logic [LW-1:0] stack_level
);

    assert_start_runs_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (busy_o && !error_o && !frozen_o));

    assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (error_o && !start_i) |=> error_o);

    assert_err_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error_o) |-> !busy_o);

    assert_frozen_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen_o && !start_i) |=> (frozen_o && !wr_en_o));

    assert_flags_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(frozen_o && busy_o));

    assert_write_when_running_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> $past(busy_o));

    assert_stack_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stack_level <= LW'(DEPTH));

endmodule

bind snd_seq_engine snd_seq_engine_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .wr_en_o     (wr_en_o),
    .busy_o      (busy_o),
    .frozen_o    (frozen_o),
    .error_o     (error_o),
    .stack_level (stack_level)
);

// File: tb/test_snd_seq_engine.sv
`timescale 1ns/1ps
module test_snd_seq_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] start_addr = '0;
    logic        tick = 1'b1;
    logic [15:0] pmem_addr;
    logic [7:0]  pmem_data;
    logic        wr_en;
    logic [3:0]  wr_reg;
    logic [7:0]  wr_data;
    logic        busy, frozen, error;

    logic [7:0]  pmem [256];
    int          checks = 0;
    int          fails = 0;
    int          cyc = 0;
    int          nw = 0;
    logic [3:0]  log_reg [64];
    logic [7:0]  log_dat [64];
    int          log_cyc [64];

    always #2 clk = ~clk;

    assign pmem_data = pmem[pmem_addr[7:0]];

    snd_seq_engine i_snd_seq_engine (
        .clk (clk), .rst_n (rst_n), .start_i (start), .start_addr_i (start_addr),
        .tick_i (tick), .pmem_addr_o (pmem_addr), .pmem_data_i (pmem_data),
        .wr_en_o (wr_en), .wr_reg_o (wr_reg), .wr_data_o (wr_data),
        .busy_o (busy), .frozen_o (frozen), .error_o (error)
    );

    // Cycle counter and write log, sampled away from the active edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (wr_en && nw < 64) begin
            log_reg[nw] = wr_reg;
            log_dat[nw] = wr_data;
            log_cyc[nw] = cyc;
            nw = nw + 1;
        end
    end

    // Opcode, register, initial value, operand, expected final value
    localparam int NVEC = 6;
    localparam logic [31:0] VEC [NVEC] = '{
        {4'h0, 4'h2, 8'h11, 8'h5A, 8'h5A},
        {4'h1, 4'h3, 8'hFF, 8'h00, 8'h00},
        {4'h2, 4'h4, 8'h00, 8'h00, 8'hFF},
        {4'h3, 4'h5, 8'hF0, 8'h20, 8'h10},
        {4'h4, 4'h6, 8'h05, 8'h07, 8'hFE},
        {4'h1, 4'hF, 8'h7F, 8'h00, 8'h80}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_range(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic fill_stop();
        for (int i = 0; i < 256; i++) pmem[i] = 8'hF0;
    endtask

    task automatic do_start(input logic [15:0] a);
        @(negedge clk);
        nw = 0;
        start = 1'b1;
        start_addr = a;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic settle(input int maxc);
        for (int i = 0; i < maxc; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        fill_stop();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy", busy, 0);
        chk("R1 frozen", frozen, 0);
        chk("R1 error", error, 0);
        chk("R1 wr_en", wr_en, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 idle after reset", {busy, nw[0]}, 0);

        // R3 R4: arithmetic vectors
        for (int v = 0; v < NVEC; v++) begin
            logic [3:0] op, rg;
            logic [7:0] ini, bb, ex;
            {op, rg, ini, bb, ex} = VEC[v];
            fill_stop();
            pmem[0] = {4'h0, rg};
            pmem[1] = ini;
            pmem[2] = {op, rg};
            if (op == 4'h1 || op == 4'h2) pmem[3] = 8'hF0;
            else pmem[3] = bb;
            do_start(16'h0000);
            settle(100);
            chk("R3/R4 write count", nw, 2);
            chk("R3/R4 register", log_reg[1], rg);
            chk("R3/R4 value", log_dat[1], ex);
        end

        // R5: BEQ taken skips a store
        fill_stop();
        pmem[0] = 8'h01; pmem[1] = 8'h00;
        pmem[2] = 8'h61; pmem[3] = 8'h02;
        pmem[4] = 8'h02; pmem[5] = 8'hAA;
        pmem[6] = 8'h03; pmem[7] = 8'h55;
        do_start(16'h0000);
        settle(100);
        chk("R5 beq count", nw, 2);
        chk("R5 beq target", {log_reg[1], log_dat[1]}, {4'h3, 8'h55});

        // R5: BNE backward loop counting down, then BRA over a store
        fill_stop();
        pmem[0] = 8'h04; pmem[1] = 8'h03;
        pmem[2] = 8'h24;
        pmem[3] = 8'h74; pmem[4] = 8'hFD;
        pmem[5] = 8'h50; pmem[6] = 8'h02;
        pmem[7] = 8'h0E; pmem[8] = 8'h99;
        pmem[9] = 8'h0D; pmem[10] = 8'h44;
        do_start(16'h0000);
        settle(200);
        chk("R5 loop count", nw, 5);
        chk("R5 loop end", log_dat[3], 8'h00);
        chk("R5 bra target", {log_reg[4], log_dat[4]}, {4'hD, 8'h44});

        // R2: no-op opcodes 9, C, D with lengths 1, 2, 2
        fill_stop();
        pmem[0] = 8'h93;
        pmem[1] = 8'hC1; pmem[2] = 8'h0F;
        pmem[3] = 8'hD2; pmem[4] = 8'h0F;
        pmem[5] = 8'h08; pmem[6] = 8'h3C;
        do_start(16'h0000);
        settle(100);
        chk("R2 nop count", nw, 1);
        chk("R2 nop lengths", {log_reg[0], log_dat[0]}, {4'h8, 8'h3C});

        // R6: explicit wait of 1×256 ticks
        fill_stop();
        pmem[0] = 8'h00; pmem[1] = 8'h01;
        pmem[2] = 8'h81; pmem[3] = 8'h01;
        pmem[4] = 8'h00; pmem[5] = 8'h02;
        tick = 1'b1;
        do_start(16'h0000);
        settle(2000);
        chk("R6 wait writes", nw, 2);
        chk_range("R6 wait gap", log_cyc[1] - log_cyc[0], 260, 266);

        // R6: default wait of 4096 ticks
        pmem[2] = 8'h80; pmem[3] = 8'h01;
        do_start(16'h0000);
        settle(6000);
        chk_range("R6 default gap", log_cyc[1] - log_cyc[0], 4100, 4106);

        // R6: no progress while tick is low
        pmem[2] = 8'h81;
        tick = 1'b0;
        do_start(16'h0000);
        repeat (400) @(negedge clk);
        chk("R6 stalled without tick", {busy, 8'(nw)}, {1'b1, 8'd1});
        tick = 1'b1;
        settle(1000);
        chk("R6 resumes with tick", nw, 2);

        // R7: call and return
        fill_stop();
        pmem[0] = 8'hA0; pmem[1] = 8'h00; pmem[2] = 8'h10;
        pmem[3] = 8'h05; pmem[4] = 8'h77;
        pmem[16] = 8'h06; pmem[17] = 8'h66;
        pmem[18] = 8'hB0;
        do_start(16'h0000);
        settle(100);
        chk("R7 call count", nw, 2);
        chk("R7 subroutine first", {log_reg[0], log_dat[0]}, {4'h6, 8'h66});
        chk("R7 return point", {log_reg[1], log_dat[1]}, {4'h5, 8'h77});
        chk("R7 no error", error, 0);

        // R8: overflow on the fifth nested call
        fill_stop();
        pmem[0] = 8'hA0; pmem[1] = 8'h00; pmem[2] = 8'h00;
        do_start(16'h0000);
        settle(100);
        chk("R8 overflow error", {error, busy}, 2'b10);
        repeat (10) @(negedge clk);
        chk("R8 error holds", error, 1);

        // R11: start clears the error
        do_start(16'h0080);
        chk("R11 error cleared", error, 0);
        settle(100);

        // R8: underflow on return with empty stack
        fill_stop();
        pmem[0] = 8'hB0;
        do_start(16'h0000);
        settle(100);
        chk("R8 underflow error", {error, busy, 8'(nw)}, {2'b10, 8'd0});

        // R9: freeze and resume with a new start
        fill_stop();
        pmem[0] = 8'h07; pmem[1] = 8'h01;
        pmem[2] = 8'hE0;
        pmem[3] = 8'h07; pmem[4] = 8'h02;
        pmem[64] = 8'h0A; pmem[65] = 8'h5C;
        do_start(16'h0000);
        settle(100);
        repeat (20) @(negedge clk);
        chk("R9 frozen", {frozen, busy}, 2'b10);
        chk("R9 no writes while frozen", nw, 1);
        do_start(16'h0040);
        chk("R9 unfrozen by start", frozen, 0);
        settle(100);
        chk("R9 new program ran", {log_reg[0], log_dat[0]}, {4'hA, 8'h5C});

        // R10: stop ends the program
        repeat (20) @(negedge clk);
        chk("R10 stopped", {busy, 8'(nw)}, {1'b0, 8'd1});

        // R11: restart during a wait inside a call clears the stack
        fill_stop();
        pmem[0] = 8'hA0; pmem[1] = 8'h00; pmem[2] = 8'h10;
        pmem[16] = 8'h88; pmem[17] = 8'h40;
        pmem[48] = 8'h09; pmem[49] = 8'h22;
        pmem[50] = 8'hB0;
        do_start(16'h0000);
        repeat (30) @(negedge clk);
        chk("R11 waiting", busy, 1);
        do_start(16'h0030);
        settle(100);
        chk("R11 restart write", {log_reg[0], log_dat[0]}, {4'h9, 8'h22});
        chk("R11 stack cleared", error, 1);

        // R12: write strobe lasts one cycle
        fill_stop();
        pmem[0] = 8'h01; pmem[1] = 8'h10;
        do_start(16'h0000);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (wr_en) break;
        end
        chk("R12 strobe high", wr_en, 1);
        @(negedge clk);
        chk("R12 strobe one cycle", wr_en, 0);
        settle(100);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule